// File: doc/BRIEF.md
# AHB-Lite to APB Bridge with Eight-Way Peripheral Select

This block connects an AHB-Lite subordinate port to an APB manager port on a single shared clock. It latches the address and direction of each accepted AHB transfer at the end of its address phase. It then runs the APB setup phase and the access phase, returns read data and the response to AHB through registers, and turns an APB subordinate error into a two-cycle AHB ERROR response. Address bits [14:12] of the captured address choose one of eight APB subordinates, so each one owns a 4 KB window. The same bits steer the return multiplexer for read data, ready and error.

The control sequence lives in one state machine with six named states. ST_IDLE means no transfer is pending. ST_SETUP is the one-cycle APB setup phase. ST_ACCESS is the APB access phase, held while the selected ready is low. ST_DONE is the registered OKAY completion cycle. ST_ERR1 and ST_ERR2 are the two cycles of the ERROR response.

The transitions are:
- start (ST_IDLE, ST_DONE or ST_ERR2 to ST_SETUP), when HSEL, HTRANS[1] and HREADY are all high. Without a start, those states go to ST_IDLE.
- enter_access (ST_SETUP to ST_ACCESS).
- wait (ST_ACCESS to itself) while the selected ready is low.
- finish_ok (ST_ACCESS to ST_DONE) when ready is high and the error input is low.
- finish_err (ST_ACCESS to ST_ERR1) when ready and the error input are both high.
- err_hold (ST_ERR1 to ST_ERR2).

Top module: `ahb_apb_bridge`

## Requirements
- R1: While reset is asserted, and right after it is released, hreadyout is 1, hresp is 0, every psel line is 0, penable is 0 and hrdata is 0.
- R2: A transfer is accepted only on a clock edge where hsel, htrans[1] and hready are all 1. IDLE (htrans=00) or BUSY (htrans=01) transfers, and NONSEQ with hready low, get hreadyout=1 and hresp=0 and cause no APB activity.
- R3: The address and hwrite value sampled at acceptance appear on paddr and pwrite for the whole APB transfer. They stay stable while penable is high.
- R4: psel is the one-hot decode of captured address bits [14:12]: value k drives psel[k]. At most one psel line is high at any time.
- R5: The cycle after acceptance is the setup phase (psel high, penable 0). The access phase follows (psel and penable high) and lasts as long as the selected pready is low.
- R6: Only the selected subordinate's prdata, pready and pslverr affect the block. The other ports are ignored, whatever they drive.
- R7: On a read, the selected prdata is captured on the clock edge that ends the access phase. It appears on hrdata in the following cycle and holds until the next read completes.
- R8: hreadyout is 0 from the setup cycle through the last access cycle. A successful transfer completes with hreadyout=1 and hresp=0 in the cycle after the access phase ends.
- R9: pwdata follows hwdata directly, with no register.
- R10: If pslverr is high when the access phase ends (read or write), the next cycle has hresp=1 and hreadyout=0, and the cycle after has hresp=1 and hreadyout=1.
- R11: A transfer accepted in the completion cycle or in the second error cycle starts its setup phase in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Shared AHB/APB clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Bridge select from the AHB decoder |
| haddr | input | ADDR_W | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB direction, 1 = write |
| hwdata | input | DATA_W | AHB write data |
| hready | input | 1 | AHB bus ready |
| hrdata | output | DATA_W | Registered read data |
| hreadyout | output | 1 | Bridge ready to AHB |
| hresp | output | 1 | AHB response, 1 = ERROR |
| paddr | output | ADDR_W | APB address |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| penable | output | 1 | APB access phase strobe |
| psel | output | NUM_SLV | One-hot APB subordinate selects |
| prdata | input | NUM_SLV*DATA_W | Read data, subordinate k at bits [k*DATA_W +: DATA_W] |
| pready | input | NUM_SLV | Per-subordinate ready |
| pslverr | input | NUM_SLV | Per-subordinate error |

## Verification
Take the cycle in which a transfer is accepted as cycle A. The setup phase is due in A+1, the first access cycle in A+2, and the completion or first error cycle comes one cycle after the access cycle in which pready is high. hrdata changes in that same completion cycle, and the second error cycle follows one cycle later. The bench's reference model advances one state per clock from the values the bench has just driven. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due. Subordinates that are not selected drive ready low, error high and junk data, so any leak through the return path shows up at once.

// File: rtl/ahb_apb_pkg.sv
package ahb_apb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACCESS = 3'd2,
        ST_DONE   = 3'd3,
        ST_ERR1   = 3'd4,
        ST_ERR2   = 3'd5
    } brg_state_t;

    // States in which a new AHB transfer may be accepted
    function automatic logic can_accept(brg_state_t s);
        return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_ERR2);
    endfunction

endpackage

// File: rtl/apb_sel_decode.sv
module apb_sel_decode #(
    parameter int NUM_SLV = 8,
    localparam int IDX_W = $clog2(NUM_SLV)
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic               en,
    output logic [NUM_SLV-1:0] sel
);
    for (genvar g = 0; g < NUM_SLV; g++) begin : g_line
        assign sel[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/apb_ret_mux.sv
module apb_ret_mux #(
    parameter int NUM_SLV = 8,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_SLV)
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [NUM_SLV*DATA_W-1:0] prdata,
    input  logic [NUM_SLV-1:0]        pready,
    input  logic [NUM_SLV-1:0]        pslverr,
    output logic [DATA_W-1:0]         sel_rdata,
    output logic                      sel_ready,
    output logic                      sel_err
);
    logic [NUM_SLV-1:0] hit;
    logic [DATA_W-1:0]  term [NUM_SLV];

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_leg
        assign hit[g]  = (idx == IDX_W'(g));
        assign term[g] = hit[g] ? prdata[g*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        sel_rdata = '0;
        for (int i = 0; i < NUM_SLV; i++) begin
            sel_rdata = sel_rdata | term[i];
        end
    end

    assign sel_ready = |(pready & hit);
    assign sel_err   = |(pslverr & hit);
endmodule

// File: rtl/ahb_apb_fsm.sv
module ahb_apb_fsm
    import ahb_apb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sel_ready,
    input  logic sel_err,
    output logic cap_en,
    output logic rd_done,
    output logic apb_sel,
    output logic apb_en,
    output logic hrdy,
    output logic herr
);
    brg_state_t state;

    // State register with next-state selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_DONE, ST_ERR2: state <= start ? ST_SETUP : ST_IDLE;
                ST_SETUP:                  state <= ST_ACCESS;
                ST_ACCESS: begin
                    if (sel_ready) state <= sel_err ? ST_ERR1 : ST_DONE;
                    else           state <= ST_ACCESS;
                end
                ST_ERR1:                   state <= ST_ERR2;
                default:                   state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        cap_en  = can_accept(state) && start;
        rd_done = 1'b0;
        apb_sel = 1'b0;
        apb_en  = 1'b0;
        hrdy    = 1'b1;
        herr    = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: ;
            ST_SETUP: begin
                apb_sel = 1'b1;
                hrdy    = 1'b0;
            end
            ST_ACCESS: begin
                apb_sel = 1'b1;
                apb_en  = 1'b1;
                hrdy    = 1'b0;
                rd_done = sel_ready;
            end
            ST_ERR1: begin
                hrdy = 1'b0;
                herr = 1'b1;
            end
            ST_ERR2: herr = 1'b1;
            default: ;
        endcase
    end

    // R5: the access phase persists while the selected ready is low
    p_access_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && !sel_ready) |=> (state == ST_ACCESS));

    // R10: a completing access with an error enters the first error cycle
    p_err_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCESS && sel_ready && sel_err) |=> (state == ST_ERR1));
endmodule

// File: rtl/ahb_apb_bridge.sv
module ahb_apb_bridge #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NUM_SLV = 8,
    parameter int SEL_LSB = 12
) (
    input  logic                      hclk,
    input  logic                      hresetn,
    input  logic                      hsel,
    input  logic [ADDR_W-1:0]         haddr,
    input  logic [1:0]                htrans,
    input  logic                      hwrite,
    input  logic [DATA_W-1:0]         hwdata,
    input  logic                      hready,
    output logic [DATA_W-1:0]         hrdata,
    output logic                      hreadyout,
    output logic                      hresp,
    output logic [ADDR_W-1:0]         paddr,
    output logic                      pwrite,
    output logic [DATA_W-1:0]         pwdata,
    output logic                      penable,
    output logic [NUM_SLV-1:0]        psel,
    input  logic [NUM_SLV*DATA_W-1:0] prdata,
    input  logic [NUM_SLV-1:0]        pready,
    input  logic [NUM_SLV-1:0]        pslverr
);
    localparam int IDX_W = $clog2(NUM_SLV);
    localparam int IDX_H = SEL_LSB + IDX_W - 1;

    logic              start;
    logic              cap_en;
    logic              rd_done;
    logic              apb_sel;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sel_rdata;
    logic              sel_ready;
    logic              sel_err;

    assign start = hsel && htrans[1] && hready;
    assign idx   = paddr[IDX_H:SEL_LSB];

    // Address and direction captured at the end of the address phase
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            paddr  <= '0;
            pwrite <= 1'b0;
        end else if (cap_en) begin
            paddr  <= haddr;
            pwrite <= hwrite;
        end
    end

    // Read data registered before it returns to AHB
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn)                hrdata <= '0;
        else if (rd_done && !pwrite) hrdata <= sel_rdata;
    end

    assign pwdata = hwdata;

    ahb_apb_fsm u_fsm (
        .clk       (hclk),
        .rst_n     (hresetn),
        .start     (start),
        .sel_ready (sel_ready),
        .sel_err   (sel_err),
        .cap_en    (cap_en),
        .rd_done   (rd_done),
        .apb_sel   (apb_sel),
        .apb_en    (penable),
        .hrdy      (hreadyout),
        .herr      (hresp)
    );

    apb_sel_decode #(.NUM_SLV(NUM_SLV)) u_dec (
        .idx (idx),
        .en  (apb_sel),
        .sel (psel)
    );

    apb_ret_mux #(.NUM_SLV(NUM_SLV), .DATA_W(DATA_W)) u_mux (
        .idx       (idx),
        .prdata    (prdata),
        .pready    (pready),
        .pslverr   (pslverr),
        .sel_rdata (sel_rdata),
        .sel_ready (sel_ready),
        .sel_err   (sel_err)
    );

    // R4: never more than one subordinate selected
    p_psel_onehot_r4: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(psel));

    // R5: penable only rises after a setup cycle with a select and no enable
    p_setup_first_r5: assert property (@(posedge hclk) disable iff (!hresetn)
        $rose(penable) |-> ($past(|psel) && !$past(penable)));

    // R3: address and direction hold steady across the access phase
    p_addr_stable_r3: assert property (@(posedge hclk) disable iff (!hresetn)
        (penable && $past(penable)) |-> ($stable(paddr) && $stable(pwrite)));

    // R8: AHB is stalled while an APB transfer is in flight
    p_stall_r8: assert property (@(posedge hclk) disable iff (!hresetn)
        (|psel) |-> !hreadyout);

    // R10: the first error cycle is followed by the second
    p_err_pair_r10: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    // R10: the second error cycle is always preceded by the first
    p_err_order_r10: assert property (@(posedge hclk) disable iff (!hresetn)
        (hresp && hreadyout) |-> $past(hresp && !hreadyout));
endmodule

// File: tb/tb_ahb_apb_bridge.sv
`timescale 1ns/1ps
module tb_ahb_apb_bridge;
    localparam int AW = 32, DW = 32, NS = 8;
    localparam int WATCHDOG = 100000;

    typedef struct {
        logic [31:0] addr;
        logic        wr;
        logic [31:0] wdata;
        int          waits;
        logic        err;
        int          gap;
        int          gap_kind;
    } txn_t;

    // Reference model states
    localparam int M_IDLE = 0, M_SETUP = 1, M_ACC = 2, M_DONE = 3, M_E1 = 4, M_E2 = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsel = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [1:0] htrans = 2'b00;
    logic hwrite = 1'b0;
    logic [DW-1:0] hwdata = '0;
    logic hready = 1'b1;
    logic [DW-1:0] hrdata;
    logic hreadyout, hresp, pwrite, penable;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic [NS-1:0] psel;
    logic [NS*DW-1:0] prdata = '0;
    logic [NS-1:0] pready = '0;
    logic [NS-1:0] pslverr = '0;

    always #2 clk = ~clk;

    ahb_apb_bridge dut (
        .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hwdata(hwdata), .hready(hready), .hrdata(hrdata),
        .hreadyout(hreadyout), .hresp(hresp), .paddr(paddr), .pwrite(pwrite),
        .pwdata(pwdata), .penable(penable), .psel(psel), .prdata(prdata),
        .pready(pready), .pslverr(pslverr)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    txn_t q[$];
    int gap_left = -1;
    logic issued_last = 1'b0;
    logic [31:0] pend_wdata = '0;
    int cfg_wait[NS];
    logic cfg_err[NS];
    int acc_cnt[NS];

    int m_st = M_IDLE;
    logic [31:0] m_addr = '0, m_wdata = '0, m_rdata = '0;
    logic m_wr = 1'b0;
    int m_idx = 0;
    int m_prev = M_IDLE;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h cycle=%0d", tag, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R8 act=timeout exp=completion");
            summary();
        end
        if (!rst_n) begin
            // R1: reset values
            chk("R1", hreadyout, 1, "hreadyout");
            chk("R1", hresp, 0, "hresp");
            chk("R1", psel, 0, "psel");
            chk("R1", penable, 0, "penable");
            chk("R1", hrdata, 0, "hrdata");
            m_st = M_IDLE; m_rdata = '0;
            for (int i = 0; i < NS; i++) begin
                acc_cnt[i] = 0; cfg_wait[i] = 0; cfg_err[i] = 1'b0;
            end
        end else begin
            // Compare every output against the model for this cycle
            begin
                logic e_ho, e_hr, e_pen;
                logic [NS-1:0] e_psel;
                string t_ho, t_ps;
                e_ho   = !(m_st == M_SETUP || m_st == M_ACC || m_st == M_E1);
                e_hr   = (m_st == M_E1 || m_st == M_E2);
                e_pen  = (m_st == M_ACC);
                e_psel = (m_st == M_SETUP || m_st == M_ACC) ? (NS'(1) << m_idx) : '0;
                t_ho   = (m_st == M_IDLE) ? "R2" : ((m_st == M_E1 || m_st == M_E2) ? "R10" : "R8");
                t_ps   = (m_st == M_SETUP && (m_prev == M_DONE || m_prev == M_E2)) ? "R11" : "R4";
                chk(t_ho, hreadyout, e_ho, "hreadyout");
                chk(e_hr ? "R10" : "R8", hresp, e_hr, "hresp");
                chk(t_ps, psel, e_psel, "psel");
                chk("R5", penable, e_pen, "penable");
                chk("R7 R6", hrdata, m_rdata, "hrdata");
                chk("R9", pwdata, hwdata, "pwdata follows hwdata");
                if (m_st == M_SETUP || m_st == M_ACC) begin
                    chk("R3", paddr, m_addr, "paddr");
                    chk("R3", pwrite, m_wr, "pwrite");
                end
                if (m_st == M_ACC && m_wr) chk("R9", pwdata, m_wdata, "pwdata write value");
            end

            // AHB manager stimulus
            if (issued_last) begin
                hwdata = pend_wdata;
                issued_last = 1'b0;
            end
            hsel = 1'b0; htrans = 2'b00; hready = hreadyout;
            if (hreadyout && q.size() > 0) begin
                if (gap_left < 0) gap_left = q[0].gap;
                if (gap_left > 0) begin
                    hsel  = 1'b1;
                    haddr = 32'h0000_5000 + 32'(cyc);
                    hwrite = cyc[0];
                    case (q[0].gap_kind)
                        0: hsel = 1'b0;
                        1: htrans = 2'b00;
                        2: htrans = 2'b01;
                        default: begin htrans = 2'b10; hready = 1'b0; end
                    endcase
                    gap_left--;
                end else begin
                    txn_t t;
                    t = q.pop_front();
                    hsel = 1'b1; htrans = 2'b10; haddr = t.addr; hwrite = t.wr;
                    cfg_wait[t.addr[14:12]] = t.waits;
                    cfg_err[t.addr[14:12]]  = t.err;
                    pend_wdata = t.wdata;
                    issued_last = 1'b1;
                    gap_left = -1;
                end
            end

            // APB subordinates react to the bridge outputs of this cycle
            for (int i = 0; i < NS; i++) begin
                if (psel[i] && penable) begin
                    pready[i]  = (acc_cnt[i] >= cfg_wait[i]);
                    pslverr[i] = pready[i] && cfg_err[i];
                    prdata[i*DW +: DW] = {4'hC, 4'(i), paddr[23:0]};
                    acc_cnt[i]++;
                end else begin
                    acc_cnt[i] = 0;
                    pready[i]  = 1'b0;
                    pslverr[i] = 1'b1;
                    prdata[i*DW +: DW] = 32'hDEAD_0000 | 32'(i);
                end
            end

            // Reference model: advance with the values the DUT sees at the next edge
            m_prev = m_st;
            case (m_st)
                M_IDLE, M_DONE, M_E2: begin
                    if (hsel && htrans[1] && hready) begin
                        m_st = M_SETUP; m_addr = haddr; m_wr = hwrite;
                        m_idx = int'(haddr[14:12]); m_wdata = pend_wdata;
                    end else m_st = M_IDLE;
                end
                M_SETUP: m_st = M_ACC;
                M_ACC: if (pready[m_idx]) begin
                    if (!m_wr) m_rdata = prdata[m_idx*DW +: DW];
                    m_st = pslverr[m_idx] ? M_E1 : M_DONE;
                end
                M_E1: m_st = M_E2;
                default: m_st = M_IDLE;
            endcase
        end
    end

    initial begin
        for (int k = 0; k < 40; k++) begin
            txn_t t;
            t.addr  = (32'(k) << 16) | (32'(k % 8) << 12) | ((32'(k) * 4) & 32'hFFC);
            t.wr    = (k % 2 == 1);
            t.wdata = 32'h1234_0000 ^ (32'(k) * 32'h0101_0101);
            t.waits = (k % 4 == 3) ? 3 : (k % 3);
            t.err   = (k % 7 == 4) || (k == 11);
            t.gap   = (k % 5 == 0) ? 0 : (k % 4);
            t.gap_kind = (k / 2) % 4;
            q.push_back(t);
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wait (q.size() == 0);
        repeat (12) @(negedge clk);
        summary();
    end
endmodule